// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of a 256-row dynamic memory refreshed inside the retention window. A free-running interval timer issues one refresh credit every retention/rows period, and credits queue in a small backlog while the strobe bus is busy. With at least one credit pending, the block raises a bus request toward the access sequencer. When the grant arrives, the block takes the bus and drives the row strobe, the column strobe and the 9-bit address bus for one refresh cycle. It then returns the bus and advances its internal row counter.

There are two refresh styles, and the choice is made at the grant. If the sequencer has just finished a read and is holding the column strobe low (`rd_hold_i` high), the block keeps the column strobe low for the whole refresh and pulses only the row strobe. The read data on the memory output stays valid, because only the column strobe controls that output. Otherwise the column strobe stays high and the refresh touches only the row strobe. In both styles the refresh row goes out explicitly on the address pins, because the memory has no internal refresh counter for these styles.

All timing is derived from the clock frequency and nanosecond limits by functions in the package. Each refresh has three phases: a precharge phase with the row strobe high, a low phase, and a closing precharge phase before the bus is released.

Top module: `dram_refresh_sched`

## Requirements
- R1: In reset and afterwards until the first credit, the outputs are req_o=0, own_o=0, ras_n_o=1, cas_n_o=1, addr_o=0 and err_o=0. No request appears before one full interval has elapsed.
- R2: A refresh credit is issued every INTERVAL = floor(CLK_KHZ*RETENTION_US/(1000*ROWS)) clock cycles. With the grant always available, consecutive refresh starts (rising own_o) are exactly INTERVAL cycles apart, and all ROWS rows are refreshed within RETENTION_US.
- R3: Up to MAX_PEND credits accumulate while no grant is given. A credit that arrives when MAX_PEND are already pending sets err_o, which stays high until reset. A backlog drains back to back, with starts 2*PRE_CYC+LOW_CYC+1 cycles apart.
- R4: req_o is high whenever a credit is pending and the block does not hold the bus. own_o rises in the cycle after req_o and gnt_i are both high. Without a grant, own_o stays low and both strobes stay high.
- R5: If rd_hold_i is low when the grant is taken, cas_n_o stays high for the whole time the block holds the bus (row-strobe-only refresh).
- R6: If rd_hold_i is high when the grant is taken, cas_n_o stays low for the whole time the block holds the bus, while ras_n_o makes one high-low-high pulse (hidden refresh).
- R7: While the bus is held, the row strobe is high for PRE_CYC = ceil(50 ns / Tclk) cycles before it falls. It is then low for LOW_CYC = max(ceil(70 ns / Tclk), ceil(130 ns / Tclk) - PRE_CYC) cycles, and high again for PRE_CYC cycles before the bus is released.
- R8: The refresh row goes out on addr_o[7:0] with addr_o[8]=0. The row starts at 0 after reset, increments by one after each completed refresh, and wraps from 255 to 0.
- R9: addr_o and cas_n_o do not change while the bus is held. addr_o is 0 whenever the bus is not held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gnt_i | input | 1 | Bus grant from the access sequencer |
| rd_hold_i | input | 1 | Sequencer just finished a read and holds the column strobe low |
| req_o | output | 1 | Bus request, a refresh credit is pending |
| own_o | output | 1 | Block drives the strobes and address bus |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ADDR_W (9) | Multiplexed address bus carrying the refresh row |
| err_o | output | 1 | Sticky backlog overflow flag |

## Verification
The embedded properties check several rules on every cycle. They check the row-strobe low width and the precharge before the fall and after the rise. They check that the column strobe and the address do not change while the bus is held, and that the bus is taken one cycle after request and grant. They also check that the backlog never exceeds its limit, that the error flag is sticky, and that the row advances by one per refresh. Only the bench scenarios can show the rest: the exact spacing of refresh starts against the interval, all rows fitting in the retention window, the wrap from row 255 to 0, the overflow occurring on the ninth credit and not the eighth, and the choice of refresh style following rd_hold_i at each grant.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_LOW, PH_POST} rfsh_phase_e;

  // cycles covering at least ns nanoseconds at clk_khz, rounded up
  function automatic int ns_to_cyc(int ns, int clk_khz);
    longint prod;
    prod = longint'(ns) * longint'(clk_khz);
    return int'((prod + longint'(999999)) / longint'(1000000));
  endfunction

  // cycles between refresh credits: retention window split over all rows
  function automatic int rfsh_interval(int clk_khz, int ret_us, int rows);
    return int'((longint'(clk_khz) * longint'(ret_us)) / (longint'(1000) * longint'(rows)));
  endfunction

  // low phase long enough for both the pulse-width and the full-cycle limit
  function automatic int ras_low_cyc(int clk_khz, int low_ns, int rc_ns, int pre_ns);
    int a;
    int b;
    a = ns_to_cyc(low_ns, clk_khz);
    b = ns_to_cyc(rc_ns, clk_khz) - ns_to_cyc(pre_ns, clk_khz);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
  parameter int INTERVAL = 3906
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == TW'(INTERVAL - 1));
  assign tick_o = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic done_i,
  output logic pend_nz_o,
  output logic err_o
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] pend_q;
  logic          full;
  logic          err_q;

  assign full      = (pend_q == PW'(MAX_PEND));
  assign pend_nz_o = (pend_q != '0);
  assign err_o     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case ({tick_i, done_i})
        2'b10: begin
          if (full) err_q  <= 1'b1;
          else      pend_q <= pend_q + 1'b1;
        end
        2'b01:   if (pend_q != '0) pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(MAX_PEND)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R3

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PRE_CYC = 13,
  parameter int LOW_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hidden_i,
  output logic own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic done_o
);
  localparam int CMAX = (PRE_CYC > LOW_CYC) ? PRE_CYC : LOW_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int RW   = CW + 1;

  rfsh_phase_e   ph_q;
  logic [CW-1:0] cnt_q;
  logic          hid_q;
  logic          last;

  assign last    = (cnt_q == '0);
  assign own_o   = (ph_q != PH_IDLE);
  assign ras_n_o = (ph_q != PH_LOW);
  assign cas_n_o = ~(own_o & hid_q);
  assign done_o  = (ph_q == PH_POST) && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      hid_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_PRE;
          cnt_q <= CW'(PRE_CYC - 1);
          hid_q <= hidden_i;
        end
        PH_PRE: if (last) begin
          ph_q  <= PH_LOW;
          cnt_q <= CW'(LOW_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_LOW: if (last) begin
          ph_q  <= PH_POST;
          cnt_q <= CW'(PRE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_POST: if (last) ph_q <= PH_IDLE;
                 else      cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // run-length observers for the strobe timing properties
  logic [RW-1:0] low_run_q;
  logic [RW-1:0] hi_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run_q <= '0;
      hi_run_q  <= '0;
    end else begin
      low_run_q <= ras_n_o ? '0 : low_run_q + 1'b1;
      hi_run_q  <= (own_o && ras_n_o) ? hi_run_q + 1'b1 : '0;
    end
  end

  AST_RAS_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> (low_run_q == RW'(LOW_CYC))); // R7
  AST_PRECHARGE_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (hi_run_q >= RW'(PRE_CYC))); // R7
  AST_PRECHARGE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_o) |-> (hi_run_q >= RW'(PRE_CYC))); // R7
  AST_CAS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o && $past(own_o)) |-> $stable(cas_n_o)); // R6

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_KHZ      = 250000,
  parameter int RETENTION_US = 4000,
  parameter int ROWS         = 256,
  parameter int ADDR_W       = 9,
  parameter int MAX_PEND     = 8,
  parameter int T_RAS_LOW_NS = 70,
  parameter int T_RAS_PRE_NS = 50,
  parameter int T_RC_NS      = 130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_i,
  input  logic              rd_hold_i,
  output logic              req_o,
  output logic              own_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              err_o
);
  localparam int INTERVAL = rfsh_interval(CLK_KHZ, RETENTION_US, ROWS);
  localparam int PRE_CYC  = ns_to_cyc(T_RAS_PRE_NS, CLK_KHZ);
  localparam int LOW_CYC  = ras_low_cyc(CLK_KHZ, T_RAS_LOW_NS, T_RC_NS, T_RAS_PRE_NS);
  localparam int ROW_W    = $clog2(ROWS);

  logic             tick;
  logic             pend_nz;
  logic             start;
  logic             done;
  logic [ROW_W-1:0] row_q;

  rfsh_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  rfsh_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .done_i(done),
    .pend_nz_o(pend_nz), .err_o(err_o)
  );

  rfsh_strobe_seq #(.PRE_CYC(PRE_CYC), .LOW_CYC(LOW_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .hidden_i(rd_hold_i),
    .own_o(own_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .done_o(done)
  );

  assign req_o = pend_nz & ~own_o;
  assign start = req_o & gnt_i;

  always_ff @(posedge clk) begin
    if (!rst_n)    row_q <= '0;
    else if (done) row_q <= row_q + 1'b1;
  end

  generate
    if (ADDR_W > ROW_W) begin : g_pad
      assign addr_o = own_o ? {{(ADDR_W - ROW_W){1'b0}}, row_q} : '0;
    end else begin : g_trim
      assign addr_o = own_o ? ADDR_W'(row_q) : '0;
    end
  endgenerate

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (row_q == $past(row_q) + 1'b1)); // R8
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o && $past(own_o)) |-> $stable(addr_o)); // R9
  AST_GRANT_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> own_o); // R4

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int CLK_KHZ = 250000;
  localparam int RET_US  = 100;
  localparam int NROWS   = 256;
  localparam int PER_NS  = 4;
  localparam int EXP_INT = (CLK_KHZ * RET_US) / (1000 * NROWS);
  localparam int PRE_B   = (50 + PER_NS - 1) / PER_NS;
  localparam int LOW_A   = (70 + PER_NS - 1) / PER_NS;
  localparam int LOW_B   = ((130 + PER_NS - 1) / PER_NS) - PRE_B;
  localparam int LOW_E   = (LOW_A > LOW_B) ? LOW_A : LOW_B;
  localparam int DRAIN   = 2 * PRE_B + LOW_E + 1;

  // vector: {rd_hold, refresh count in this segment}
  localparam logic [4:0] TBL [6] = '{
    {1'b0, 4'd3}, {1'b1, 4'd3}, {1'b0, 4'd2},
    {1'b1, 4'd4}, {1'b0, 4'd1}, {1'b1, 4'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gnt = 1'b0;
  logic       hold = 1'b0;
  logic       req, own, ras_n, cas_n, err;
  logic [8:0] addr;

  always #2 clk = ~clk;

  dram_refresh_sched #(.CLK_KHZ(CLK_KHZ), .RETENTION_US(RET_US), .ROWS(NROWS)) u_dut (
    .clk(clk), .rst_n(rst_n), .gnt_i(gnt), .rd_hold_i(hold),
    .req_o(req), .own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .addr_o(addr), .err_o(err)
  );

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  int cyc = 0;
  int exp_gap = 0;
  string gap_tag = "R2";
  logic [7:0] exp_row = 8'd0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: strobe shape, style, address, spacing
  bit p_own = 0, seen_fall = 0, hid = 0, have_start = 0;
  int pre_len = 0, low_len = 0, post_len = 0, last_start = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_own = 0; have_start = 0; exp_row = 8'd0; done_cnt = 0;
    end else begin
      if (own && !p_own) begin
        if (have_start && exp_gap != 0)
          chk((cyc - last_start) == exp_gap, gap_tag, cyc - last_start, exp_gap);
        last_start = cyc; have_start = 1; hid = hold;
        pre_len = 0; low_len = 0; post_len = 0; seen_fall = 0;
      end
      if (own) begin
        chk(cas_n == !hid, hid ? "R6 cas held low" : "R5 cas held high", cas_n, !hid);
        chk(addr == {1'b0, exp_row}, "R8 refresh row on bus", addr, {1'b0, exp_row});
        if (!ras_n) begin low_len++; seen_fall = 1; end
        else if (seen_fall) post_len++;
        else pre_len++;
      end else begin
        chk(ras_n && cas_n, "R4 strobes idle", {ras_n, cas_n}, 3);
        chk(addr == 9'd0, "R9 bus zero when released", addr, 0);
      end
      if (!own && p_own) begin
        chk(low_len * PER_NS >= 70, "R7 low width", low_len, LOW_E);
        chk(pre_len * PER_NS >= 50, "R7 precharge before", pre_len, PRE_B);
        chk(post_len * PER_NS >= 50, "R7 precharge after", post_len, PRE_B);
        chk((pre_len + low_len) * PER_NS >= 130, "R7 cycle time", pre_len + low_len, PRE_B + LOW_E);
        exp_row++;
        done_cnt++;
      end
      p_own = own;
    end
  end

  task automatic drive_at_edge();
    @(posedge clk); #1;
  endtask

  task automatic wait_done(input int n, input string tag);
    int t = 0;
    while (done_cnt < n && t < 60000) begin @(posedge clk); t++; end
    chk(done_cnt >= n, tag, done_cnt, n);
  endtask

  task automatic do_reset(input logic g);
    drive_at_edge(); rst_n = 1'b0; gnt = g; hold = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!req && !own && ras_n && cas_n && addr == 9'd0 && !err, "R1 reset outputs",
        {req, own, ras_n, cas_n, err}, 5'b00110);
    drive_at_edge(); rst_n = 1'b1;
  endtask

  initial begin
    int target;
    int t_rel;
    do_reset(1'b1);
    t_rel = cyc;
    repeat (50) @(negedge clk);
    chk(!req && !own, "R1 no request before first interval", {req, own}, 0);

    // vector walk: refresh style per segment at steady spacing
    gap_tag = "R2 steady spacing";
    exp_gap = EXP_INT;
    target = 0;
    for (int i = 0; i < 6; i++) begin
      drive_at_edge(); hold = TBL[i][4];
      target += int'(TBL[i][3:0]);
      wait_done(target, "R4 progress in vector walk");
    end
    drive_at_edge(); hold = 1'b0;

    // all rows within retention, then the wrap 255 -> 0
    wait_done(256, "R2 progress to full sweep");
    chk((cyc - t_rel) * PER_NS <= RET_US * 1000, "R2 all rows within retention",
        (cyc - t_rel) * PER_NS, RET_US * 1000);
    begin
      int t = 0;
      @(negedge clk);
      while (!own && t < 1000) begin @(negedge clk); t++; end
      chk(own && addr == 9'd0, "R8 wrap to row 0", addr, 0);
    end
    wait_done(258, "R8 progress after wrap");

    // backlog with no grant, then overflow, then drain
    do_reset(1'b0);
    repeat (8 * EXP_INT + 10) @(negedge clk);
    chk(!err, "R3 no error at limit", err, 0);
    chk(req && !own, "R4 request without grant", {req, own}, 2);
    repeat (EXP_INT) @(negedge clk);
    chk(err, "R3 error on overflow", err, 1);
    @(posedge clk); gap_tag = "R3 back-to-back drain"; exp_gap = DRAIN;
    drive_at_edge(); gnt = 1'b1;
    wait_done(4, "R3 drain progress");
    @(negedge clk);
    chk(err, "R3 error sticky", err, 1);

    // reset clears error and row
    @(posedge clk); exp_gap = 0;
    do_reset(1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R4 watchdog expired act=%0d exp=%0d", done_cnt, 258);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule